// File: doc/BRIEF.md
# Two-Wire Scan Packet Deserializer

This block sits on the target side of a two-wire debug link that has one clock line and one bidirectional data line. The host sends scan traffic as packets of three bit periods. The first period carries the test-data-in bit, inverted. The second carries the test-mode-select bit. In the third the host releases the line, and the selected target drives back the test-data-out bit. The block collects the first two bits into a mode-select/data-in pair and presents that pair to an internal TAP controller. It pulses a one-cycle step enable so the controller advances once per packet. During the return period it drives the controller's data-out value onto the line.

The data line is sampled on the rising clock edge by default. A mode input selects sampling on the falling edge in the middle of each bit period instead, which gives the host more setup margin. Either way, the sampled bit reaches the packet logic at the same rising edge, so both modes have identical output timing. The mode input is taken while the packet is in its first slot and is then held for the rest of that packet.

Top module: `tmsc_scan_deser`

## Requirements
- R1: While `rst_n` is low, `tms` is 1, `tdi` is 0, `tap_step` is 0, `tmsc_oe` is 0 and `tmsc_out` is 0. The first rising edge after reset is released ends the first slot (slot 0) of a packet.
- R2: Slots repeat in the order 0 (inverted data-in), 1 (mode select), 2 (return). `tap_step` is high during every slot-2 period and low during slots 0 and 1.
- R3: The edge that ends slot 0 loads `tdi` with the logical inverse of the line bit sampled for slot 0. The value holds until slot 0 of the next packet ends.
- R4: The edge that ends slot 1 loads `tms` with the line bit sampled for slot 1, without inversion. The value holds until slot 1 of the next packet ends.
- R5: `tap_step` is high for exactly one cycle per packet. While it is high, `tms` and `tdi` already carry the pair of the current packet.
- R6: `tmsc_oe` is 1 only during slot 2 and only when `sel` is 1. While `tmsc_oe` is 1, `tmsc_out` equals `tap_tdo`. Otherwise `tmsc_out` is 0.
- R7: The value on `tmsc_in` during slot 2 has no effect: `tms` and `tdi` are unchanged after the edge that ends slot 2.
- R8: With `fall_mode` = 0, each slot's bit is the value of `tmsc_in` at the rising edge that ends the slot.
- R9: With `fall_mode` = 1, each slot's bit is the value of `tmsc_in` at the falling edge in the middle of the slot. The bit is applied at the same rising edge as in R8.
- R10: `fall_mode` acts directly during slot 0 and is latched at the end of slot 0. A change during slot 1 or slot 2 has no effect until the next packet's slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tckc | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmsc_in | input | 1 | Data line as seen by the input buffer |
| sel | input | 1 | This target is selected and may drive the return slot |
| fall_mode | input | 1 | 1 = sample the line on the falling edge |
| tap_tdo | input | 1 | Data-out from the internal TAP controller |
| tmsc_out | output | 1 | Value driven onto the data line |
| tmsc_oe | output | 1 | Output enable for the data line |
| tms | output | 1 | Mode-select bit to the TAP controller |
| tdi | output | 1 | Data-in bit to the TAP controller |
| tap_step | output | 1 | One-cycle advance enable for the TAP controller |

## Verification
Two things happen in the return slot at once: the block drives the line from `tap_tdo`, and the sampler still sees whatever the line carries, because it keeps sampling. The bench toggles `tmsc_in` twice during every return slot while it also sets a fresh `tap_tdo`. It then judges that `tmsc_out` follows `tap_tdo` and that `tms` and `tdi` have kept the packet's pair one edge later. A second collision is a `fall_mode` change during slot 1 while that slot's bit is glitched between the falling and rising edges. The bench checks that the value taken is the one the latched mode selects.

// File: rtl/tmsc_deser_pkg.sv
package tmsc_deser_pkg;

   typedef enum logic [1:0] {
      SLOT_NTDI = 2'd0,
      SLOT_TMS  = 2'd1,
      SLOT_TDO  = 2'd2
   } slot_e;

   localparam int unsigned PKT_SLOTS = 3;

endpackage

// File: rtl/tmsc_slot_seq.sv
module tmsc_slot_seq
   import tmsc_deser_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  fall_mode,
   output slot_e slot,
   output logic  mode_eff
);

   slot_e slot_q;
   logic  mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= SLOT_NTDI;
         mode_q <= 1'b0;
      end else begin
         slot_q <= (slot_q == SLOT_TDO) ? SLOT_NTDI : slot_e'(slot_q + 2'd1);
         if (slot_q == SLOT_NTDI)
            mode_q <= fall_mode;
      end
   end

   assign slot     = slot_q;
   assign mode_eff = (slot_q == SLOT_NTDI) ? fall_mode : mode_q;

   // R2: only three legal slot codes
   assert_slot_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      slot_q != 2'd3);

   // R2: return slot wraps to slot 0
   assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_q == SLOT_TDO) |=> (slot_q == SLOT_NTDI));

   // R10: latched mode moves only at the end of slot 0
   assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_q != SLOT_NTDI) |=> $stable(mode_q));

endmodule

// File: rtl/tmsc_edge_sampler.sv
module tmsc_edge_sampler #(
   parameter bit FALL_EDGE_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_fall,
   input  logic pin,
   output logic bit_val
);

   generate
      if (FALL_EDGE_EN) begin : g_dual
         logic neg_q;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) neg_q <= 1'b0;
            else        neg_q <= pin;
         end
         assign bit_val = mode_fall ? neg_q : pin;
      end else begin : g_rise
         logic mode_unused;
         assign mode_unused = mode_fall;
         assign bit_val     = pin | (mode_unused & 1'b0);
      end
   endgenerate

endmodule

// File: rtl/tmsc_pkt_asm.sv
module tmsc_pkt_asm
   import tmsc_deser_pkg::*;
#(
   parameter bit TDI_INVERT = 1'b1,
   parameter bit TMS_RESET  = 1'b1,
   parameter bit TDI_RESET  = 1'b0
) (
   input  logic  clk,
   input  logic  rst_n,
   input  slot_e slot,
   input  logic  bit_val,
   output logic  tms,
   output logic  tdi,
   output logic  step
);

   logic tms_q, tdi_q, step_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tms_q  <= TMS_RESET;
         tdi_q  <= TDI_RESET;
         step_q <= 1'b0;
      end else begin
         step_q <= (slot == SLOT_TMS);
         if (slot == SLOT_NTDI)
            tdi_q <= bit_val ^ TDI_INVERT;
         if (slot == SLOT_TMS)
            tms_q <= bit_val;
      end
   end

   assign tms  = tms_q;
   assign tdi  = tdi_q;
   assign step = step_q;

   // R5: step is a single-cycle pulse
   assert_step_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      step_q |=> !step_q);

   // R7: the return slot leaves the pair untouched
   assert_pair_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (slot == SLOT_TDO) |=> ($stable(tms_q) && $stable(tdi_q)));

   // R3: data-in holds through the mode-select slot
   assert_tdi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (slot == SLOT_TMS) |=> $stable(tdi_q));

endmodule

// File: rtl/tmsc_scan_deser.sv
module tmsc_scan_deser
   import tmsc_deser_pkg::*;
#(
   parameter bit FALL_EDGE_EN = 1'b1,
   parameter bit TDI_INVERT   = 1'b1,
   parameter bit TMS_RESET    = 1'b1,
   parameter bit TDI_RESET    = 1'b0,
   parameter int SLOT_W       = 2
) (
   input  logic tckc,
   input  logic rst_n,
   input  logic tmsc_in,
   input  logic sel,
   input  logic fall_mode,
   input  logic tap_tdo,
   output logic tmsc_out,
   output logic tmsc_oe,
   output logic tms,
   output logic tdi,
   output logic tap_step
);

   localparam int SLOT_W_MIN = $clog2(PKT_SLOTS);

   generate
      if (SLOT_W < SLOT_W_MIN) begin : g_bad_w
         $error("SLOT_W too narrow for the packet slot count");
      end
      if (SLOT_W != $bits(slot_e)) begin : g_bad_enc
         $error("SLOT_W must match the slot encoding");
      end
   endgenerate

   slot_e slot;
   logic  mode_eff;
   logic  bit_val;

   tmsc_slot_seq u_seq (
      .clk       (tckc),
      .rst_n     (rst_n),
      .fall_mode (fall_mode),
      .slot      (slot),
      .mode_eff  (mode_eff)
   );

   tmsc_edge_sampler #(.FALL_EDGE_EN(FALL_EDGE_EN)) u_smp (
      .clk       (tckc),
      .rst_n     (rst_n),
      .mode_fall (mode_eff),
      .pin       (tmsc_in),
      .bit_val   (bit_val)
   );

   tmsc_pkt_asm #(
      .TDI_INVERT (TDI_INVERT),
      .TMS_RESET  (TMS_RESET),
      .TDI_RESET  (TDI_RESET)
   ) u_asm (
      .clk     (tckc),
      .rst_n   (rst_n),
      .slot    (slot),
      .bit_val (bit_val),
      .tms     (tms),
      .tdi     (tdi),
      .step    (tap_step)
   );

   assign tmsc_oe  = rst_n && sel && (slot == SLOT_TDO);
   assign tmsc_out = tmsc_oe ? tap_tdo : 1'b0;

   // R6: drive only in the return slot, only when selected
   assert_oe_gated_R6: assert property (@(posedge tckc) disable iff (!rst_n)
      tmsc_oe |-> (sel && tap_step));

   // R2: step pulse and return slot coincide
   assert_step_slot_R2: assert property (@(posedge tckc) disable iff (!rst_n)
      tap_step |-> (slot == SLOT_TDO));

   // R6: released line carries no value
   assert_out_quiet_R6: assert property (@(posedge tckc) disable iff (!rst_n)
      !tmsc_oe |-> !tmsc_out);

endmodule

// File: tb/tmsc_scan_deser_tb.sv
`timescale 1ns/1ps
module tmsc_scan_deser_tb;

   logic tckc = 1'b0;
   logic rst_n, tmsc_in, sel, fall_mode, tap_tdo;
   logic tmsc_out, tmsc_oe, tms, tdi, tap_step;
   int   n_chk = 0;
   int   n_bad = 0;

   always #4 tckc = ~tckc;

   tmsc_scan_deser u_dut (
      .tckc(tckc), .rst_n(rst_n), .tmsc_in(tmsc_in), .sel(sel),
      .fall_mode(fall_mode), .tap_tdo(tap_tdo), .tmsc_out(tmsc_out),
      .tmsc_oe(tmsc_oe), .tms(tms), .tdi(tdi), .tap_step(tap_step)
   );

   task automatic chk(input logic ok, input string req, input logic act, input logic exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // Called just after a rising edge, in slot 0. Slot bits: a = value at the
   // falling edge, b = value at the rising edge. fe = mode expected to apply.
   task automatic pkt(input logic a0, b0, a1, b1, fe, s, tdo, m1);
      logic ex_tdi, ex_tms;
      ex_tdi = ~(fe ? a0 : b0);
      ex_tms = fe ? a1 : b1;
      sel = s;
      tmsc_in = a0;
      @(negedge tckc); #1 tmsc_in = b0;
      @(posedge tckc); #1;
      chk(tdi === ex_tdi, "R3 tdi after slot0", tdi, ex_tdi);
      chk(tap_step === 1'b0, "R2 step low in slot1", tap_step, 1'b0);
      chk(tmsc_oe === 1'b0, "R6 oe low in slot1", tmsc_oe, 1'b0);
      fall_mode = m1;
      tmsc_in = a1;
      @(negedge tckc); #1 tmsc_in = b1;
      @(posedge tckc); #1;
      tap_tdo = tdo;
      #1;
      chk(tms === ex_tms, "R4 tms after slot1", tms, ex_tms);
      chk(tdi === ex_tdi, "R3 tdi held", tdi, ex_tdi);
      chk(tap_step === 1'b1, "R5 step in slot2", tap_step, 1'b1);
      chk(tmsc_oe === s, "R6 oe in slot2", tmsc_oe, s);
      chk(tmsc_out === (s & tdo), "R6 out in slot2", tmsc_out, s & tdo);
      tmsc_in = ~tmsc_in;
      @(negedge tckc); #1 tmsc_in = ~tmsc_in;
      @(posedge tckc); #1;
      chk(tap_step === 1'b0, "R2 step low in slot0", tap_step, 1'b0);
      chk(tms === ex_tms, "R7 tms kept", tms, ex_tms);
      chk(tdi === ex_tdi, "R7 tdi kept", tdi, ex_tdi);
      chk(tmsc_oe === 1'b0, "R6 oe low in slot0", tmsc_oe, 1'b0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; tmsc_in = 1'b0; sel = 1'b1; fall_mode = 1'b0; tap_tdo = 1'b1;
      repeat (3) @(posedge tckc);
      #1;
      chk(tms === 1'b1, "R1 tms reset", tms, 1'b1);
      chk(tdi === 1'b0, "R1 tdi reset", tdi, 1'b0);
      chk(tap_step === 1'b0, "R1 step reset", tap_step, 1'b0);
      chk(tmsc_oe === 1'b0, "R1 oe reset", tmsc_oe, 1'b0);
      chk(tmsc_out === 1'b0, "R1 out reset", tmsc_out, 1'b0);
      rst_n = 1'b1;
   endtask

   task automatic t_basic();  // R2 R3 R4 R5 R6 R7
      pkt(1, 1, 0, 0, 0, 1, 1, 0);
      pkt(0, 0, 1, 1, 0, 1, 0, 0);
      pkt(1, 1, 1, 1, 0, 1, 1, 0);
      pkt(0, 0, 0, 0, 0, 1, 0, 0);
   endtask

   task automatic t_deselect();  // R6
      pkt(1, 1, 1, 1, 0, 0, 1, 0);
      pkt(0, 0, 0, 0, 0, 0, 1, 0);
   endtask

   task automatic t_rise_glitch();  // R8: rising-edge values win
      fall_mode = 1'b0;
      pkt(0, 1, 1, 0, 0, 1, 1, 0);
      pkt(1, 0, 0, 1, 0, 1, 0, 0);
   endtask

   task automatic t_fall_glitch();  // R9: mid-period values win
      fall_mode = 1'b1;
      pkt(0, 1, 1, 0, 1, 1, 1, 1);
      pkt(1, 0, 0, 1, 1, 1, 0, 1);
   endtask

   task automatic t_mode_mid();  // R10: mid-packet change deferred
      fall_mode = 1'b0;
      pkt(0, 1, 1, 0, 0, 1, 1, 1);
      pkt(1, 0, 0, 1, 1, 1, 0, 0);
      pkt(1, 0, 1, 0, 0, 1, 1, 0);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_deselect();
      t_rise_glitch();
      t_fall_glitch();
      t_mode_mid();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #100000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule